// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single logic-level PWM command into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. The high-side enable runs in phase with PWM and the low-side enable runs in anti-phase. The block does not wait a fixed dead time between the two. It waits for sensed evidence that the opposite switch is really off, then counts a short programmable settle delay before it turns on the next switch.

Three comparator results come in as digital bits: the low-side gate is below its threshold, the switch node is below its threshold, and the high-side gate-source voltage is discharged. If the switch node never falls, for example while the converter sinks current, a longer backup timer is used instead. It starts once the high-side gate is seen discharged, and on expiry it turns the low-side switch on anyway, so that the bootstrap capacitor is topped up every period.

Control inputs are:
- an active-low disable;
- a skip-mode control that keeps the low-side switch off at light load;
- two undervoltage events, one entering lockout and one leaving it.

Every input passes through a two-flop synchronizer. All delays are parameters in clock cycles. A configuration whose backup timeout is not longer than the low-side settle delay, or whose settle delays are zero, stops elaboration.

Top module: `buck_gate_seq`

## Requirements
- R1: In steady operation with feedback showing the opposite switch off, `hs_gate_o` is high while PWM is high, and `ls_gate_o` is high while PWM is low.
- R2: A low level on `disable_n_i` forces both gate enables low no later than 3 clock edges after it is applied, and holds them low while it stays low.
- R3: While `sync_mode_i` is low, `ls_gate_o` is low no later than 2 clock edges after the change, and `hs_gate_o` still follows PWM. Raising `sync_mode_i` again restores the low-side enable during the low half of the period.
- R4: After PWM rises, `hs_gate_o` stays low until `lsg_low_i` is seen high. It then rises exactly HS_DLY_CYC+3 clock edges after the edge that first samples `lsg_low_i` high.
- R5: After PWM falls, `ls_gate_o` stays low until `sw_low_i` is seen high. It then rises exactly LS_DLY_CYC+3 clock edges after the edge that first samples `sw_low_i` high.
- R6: After PWM falls, if `sw_low_i` stays low and `hsg_off_i` is held high, `ls_gate_o` rises exactly TMO_CYC+2 clock edges after the edge that first samples `hsg_off_i` high.
- R7: A PWM change that arrives while a turn-on is still pending cancels that turn-on. The gate that was waiting never pulses, and the sequence restarts for the new PWM level.
- R8: After reset the block is in lockout, with both enables low. A pulse on `uv_exit_i` leaves lockout, and a pulse on `uv_enter_i` enters it again, forcing both enables low within 4 clock edges. `uv_enter_i` wins if both are high together.
- R9: After reset, lockout exit or release of the disable input, both enables stay low until a low PWM level has been sampled. This holds even when PWM is high at release.
- R10: `hs_gate_o` and `ls_gate_o` are never high in the same cycle, and neither rises in a cycle in which the other was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command from the controller |
| disable_n_i | input | 1 | Low holds both gate enables off |
| sync_mode_i | input | 1 | High: synchronous mode; low: skip mode, low-side kept off |
| uv_enter_i | input | 1 | Supply fell below the lockout threshold (event) |
| uv_exit_i | input | 1 | Supply rose above the release threshold (event) |
| lsg_low_i | input | 1 | Low-side gate voltage is below its threshold |
| sw_low_i | input | 1 | Switch-node voltage is below its threshold |
| hsg_off_i | input | 1 | High-side gate-source voltage is discharged |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the sequencer with a high-side settle of 3 cycles, a low-side settle of 2 cycles and a backup timeout of 6 cycles, instead of the defaults of 5, 4 and 50. With these short windows, every exit of each wait and settle state is reached within a few cycles. That includes a PWM reversal landing inside a settle window, and the backup timer expiring before switch-node feedback arrives, both of which random stimulus reaches many times. The timeout still stays longer than the low-side settle, as the configuration check demands, so the path where switch-node feedback and timer expiry race each other is exercised as well.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  typedef enum logic [2:0] {
    ST_SAFE    = 3'd0,
    ST_LS_WAIT = 3'd1,
    ST_LS_DLY  = 3'd2,
    ST_LS_ON   = 3'd3,
    ST_HS_WAIT = 3'd4,
    ST_HS_DLY  = 3'd5,
    ST_HS_ON   = 3'd6
  } gseq_state_e;

  localparam int NUM_IN = 8;
  localparam int IX_PWM  = 7;
  localparam int IX_RUN  = 6;
  localparam int IX_SYNC = 5;
  localparam int IX_UVEN = 4;
  localparam int IX_UVEX = 3;
  localparam int IX_LSG  = 2;
  localparam int IX_SW   = 1;
  localparam int IX_HSG  = 0;
endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/gseq_lockout.sv
module gseq_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic exit_i,
  output logic locked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked_o <= 1'b1;
    else if (enter_i) locked_o <= 1'b1;
    else if (exit_i)  locked_o <= 1'b0;
  end
endmodule

// File: rtl/gseq_cnt.sv
module gseq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_o <= '0;
    else if (clr_i)  val_o <= '0;
    else if (inc_i)  val_o <= val_o + 1'b1;
  end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gseq_pkg::*;
#(
  parameter int HS_DLY_CYC = 5,
  parameter int LS_DLY_CYC = 4,
  parameter int TMO_CYC    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic disable_n_i,
  input  logic sync_mode_i,
  input  logic uv_enter_i,
  input  logic uv_exit_i,
  input  logic lsg_low_i,
  input  logic sw_low_i,
  input  logic hsg_off_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  localparam int DLY_MAX = (HS_DLY_CYC > LS_DLY_CYC) ? HS_DLY_CYC : LS_DLY_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);

  if (TMO_CYC <= LS_DLY_CYC || HS_DLY_CYC < 1 || LS_DLY_CYC < 1) begin : g_cfg_bad
    $error("buck_gate_seq: backup timeout must exceed low-side settle, settles must be >= 1");
  end

  logic [NUM_IN-1:0] raw_in, syn_in;
  logic pwm_s, run_s, sync_s, uven_s, uvex_s, lsg_s, sw_s, hsg_s;
  logic locked;

  assign raw_in = {pwm_i, disable_n_i, sync_mode_i, uv_enter_i,
                   uv_exit_i, lsg_low_i, sw_low_i, hsg_off_i};

  gseq_sync #(.W(NUM_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign pwm_s  = syn_in[IX_PWM];
  assign run_s  = syn_in[IX_RUN];
  assign sync_s = syn_in[IX_SYNC];
  assign uven_s = syn_in[IX_UVEN];
  assign uvex_s = syn_in[IX_UVEX];
  assign lsg_s  = syn_in[IX_LSG];
  assign sw_s   = syn_in[IX_SW];
  assign hsg_s  = syn_in[IX_HSG];

  gseq_lockout u_lock (
    .clk(clk), .rst_n(rst_n), .enter_i(uven_s), .exit_i(uvex_s), .locked_o(locked)
  );

  gseq_state_e state_q, state_d;
  logic in_dly, in_ls_pend, tmo_run;
  logic [DLY_W-1:0] dly_val;
  logic [TMO_W-1:0] tmo_val;

  assign in_dly     = (state_q == ST_HS_DLY) || (state_q == ST_LS_DLY);
  assign in_ls_pend = (state_q == ST_LS_WAIT) || (state_q == ST_LS_DLY);
  assign tmo_run    = in_ls_pend && hsg_s;

  gseq_cnt #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr_i(!in_dly), .inc_i(in_dly), .val_o(dly_val)
  );

  gseq_cnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr_i(!tmo_run), .inc_i(tmo_run), .val_o(tmo_val)
  );

  logic tmo_hit, hs_settled, ls_settled, drive_ok;
  assign tmo_hit    = tmo_run && (tmo_val == TMO_W'(TMO_CYC - 1));
  assign hs_settled = (dly_val == DLY_W'(HS_DLY_CYC - 1));
  assign ls_settled = (dly_val == DLY_W'(LS_DLY_CYC - 1));
  assign drive_ok   = run_s && !locked;

  always_comb begin
    state_d = state_q;
    if (!drive_ok) begin
      state_d = ST_SAFE;
    end else begin
      unique case (state_q)
        ST_SAFE:    if (!pwm_s) state_d = ST_LS_WAIT;
        ST_LS_WAIT: if (pwm_s)        state_d = ST_HS_WAIT;
                    else if (tmo_hit) state_d = ST_LS_ON;
                    else if (sw_s)    state_d = ST_LS_DLY;
        ST_LS_DLY:  if (pwm_s)                        state_d = ST_HS_WAIT;
                    else if (tmo_hit || ls_settled)   state_d = ST_LS_ON;
        ST_LS_ON:   if (pwm_s) state_d = ST_HS_WAIT;
        ST_HS_WAIT: if (!pwm_s)    state_d = ST_LS_WAIT;
                    else if (lsg_s) state_d = ST_HS_DLY;
        ST_HS_DLY:  if (!pwm_s)         state_d = ST_LS_WAIT;
                    else if (hs_settled) state_d = ST_HS_ON;
        ST_HS_ON:   if (!pwm_s) state_d = ST_LS_WAIT;
        default:    state_d = ST_SAFE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SAFE;
    else        state_q <= state_d;
  end

  assign hs_gate_o = (state_q == ST_HS_ON);
  assign ls_gate_o = (state_q == ST_LS_ON) && sync_s;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o)) else $error("gates overlap"); // R10
  AST_HS_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> $past(!ls_gate_o) && $past(pwm_s)) else $error("hs turn-on order"); // R4
  AST_LS_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> $past(!hs_gate_o) && $past(!pwm_s)) else $error("ls turn-on order"); // R5
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |=> (!hs_gate_o && !ls_gate_o)) else $error("gate on while disabled"); // R2
  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (!hs_gate_o && !ls_gate_o)) else $error("gate on in lockout"); // R8
  AST_SKIP_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_s |-> !ls_gate_o) else $error("ls on in skip mode"); // R3
endmodule

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int HSD = 3;
  localparam int LSD = 2;
  localparam int TMO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, dis_n = 1'b1, sync_m = 1'b1, uv_en = 1'b0, uv_ex = 1'b0;
  logic fb_lsg = 1'b0, fb_sw = 1'b0, fb_hsg = 1'b0;
  logic hs, ls;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hs_hits = 0;
  int ls_hits = 0;
  bit done = 1'b0;
  string g_req = "R9";

  always #5 clk = ~clk;

  buck_gate_seq #(.HS_DLY_CYC(HSD), .LS_DLY_CYC(LSD), .TMO_CYC(TMO)) i_buck_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .disable_n_i(dis_n), .sync_mode_i(sync_m),
    .uv_enter_i(uv_en), .uv_exit_i(uv_ex), .lsg_low_i(fb_lsg), .sw_low_i(fb_sw),
    .hsg_off_i(fb_hsg), .hs_gate_o(hs), .ls_gate_o(ls)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Bench reference: two-cycle input delay, then the sequencing rules of the requirements.
  logic [7:0] p1, p2;
  logic m_lk;
  int m_st, m_dly, m_tmo;

  function automatic int next_st(int st, logic [7:0] v, logic lk, int dly, int tmo);
    bit pend, hit;
    int ns;
    pend = (st == 1) || (st == 2);
    hit  = v[0] && pend && (tmo == TMO - 1);
    ns   = st;
    if (!(v[6] && !lk)) return 0;
    case (st)
      0: if (!v[7]) ns = 1;
      1: if (v[7]) ns = 4; else if (hit) ns = 3; else if (v[1]) ns = 2;
      2: if (v[7]) ns = 4; else if (hit || dly == LSD - 1) ns = 3;
      3: if (v[7]) ns = 4;
      4: if (!v[7]) ns = 1; else if (v[2]) ns = 5;
      5: if (!v[7]) ns = 1; else if (dly == HSD - 1) ns = 6;
      6: if (!v[7]) ns = 1;
      default: ns = 0;
    endcase
    return ns;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; m_lk <= 1'b1; m_st <= 0; m_dly <= 0; m_tmo <= 0;
    end else begin
      m_st  <= next_st(m_st, p2, m_lk, m_dly, m_tmo);
      m_dly <= (m_st == 2 || m_st == 5) ? m_dly + 1 : 0;
      m_tmo <= (p2[0] && (m_st == 1 || m_st == 2)) ? m_tmo + 1 : 0;
      m_lk  <= p2[4] ? 1'b1 : (p2[3] ? 1'b0 : m_lk);
      p2 <= p1;
      p1 <= {pwm, dis_n, sync_m, uv_en, uv_ex, fb_lsg, fb_sw, fb_hsg};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hs, (m_st == 6), g_req, "model hs_gate");
      chk(ls, (m_st == 3) && p2[5], g_req, "model ls_gate");
      chk(hs && ls, 1'b0, "R10", "overlap");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (hs) hs_hits++;
    if (ls) ls_hits++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    tick(4);
    rst_n = 1'b1;
    // Reset: locked, both off even with feedback present
    fb_sw = 1'b1;
    tick(10);
    chk(hs, 1'b0, "R8", "hs after reset");
    chk(ls, 1'b0, "R8", "ls after reset (locked)");
    // Leave lockout
    g_req = "R1";
    uv_ex = 1'b1; tick(1); uv_ex = 1'b0;
    tick(10);
    chk(ls, 1'b1, "R1", "ls on while pwm low");
    chk(hs, 1'b0, "R1", "hs off while pwm low");
    // Rising edge: wait for low-gate feedback then HSD settle
    g_req = "R4";
    pwm = 1'b1; fb_sw = 1'b0; fb_lsg = 1'b0;
    tick(8);
    chk(hs, 1'b0, "R4", "hs held without lsg feedback");
    chk(ls, 1'b0, "R4", "ls released on pwm rise");
    fb_lsg = 1'b1;
    tick(HSD + 2);
    chk(hs, 1'b0, "R4", "hs before settle end");
    tick(1);
    chk(hs, 1'b1, "R4", "hs at settle end");
    // Falling edge: wait for switch-node feedback then LSD settle
    g_req = "R5";
    pwm = 1'b0; fb_lsg = 1'b0; fb_sw = 1'b0; fb_hsg = 1'b0;
    tick(8);
    chk(hs, 1'b0, "R5", "hs released on pwm fall");
    chk(ls, 1'b0, "R5", "ls held without sw feedback");
    fb_sw = 1'b1;
    tick(LSD + 2);
    chk(ls, 1'b0, "R5", "ls before settle end");
    tick(1);
    chk(ls, 1'b1, "R5", "ls at settle end");
    // Backup timeout
    g_req = "R6";
    pwm = 1'b1; fb_lsg = 1'b1;
    tick(10);
    chk(hs, 1'b1, "R1", "hs on while pwm high");
    pwm = 1'b0; fb_sw = 1'b0; fb_hsg = 1'b0;
    tick(8);
    chk(ls, 1'b0, "R6", "ls waits without feedback");
    fb_hsg = 1'b1;
    tick(TMO + 1);
    chk(ls, 1'b0, "R6", "ls before timeout");
    tick(1);
    chk(ls, 1'b1, "R6", "ls forced by timeout");
    fb_hsg = 1'b0; fb_sw = 1'b1;
    // Skip mode
    g_req = "R3";
    sync_m = 1'b0;
    tick(2);
    chk(ls, 1'b0, "R3", "ls off in skip mode");
    pwm = 1'b1;
    tick(10);
    chk(hs, 1'b1, "R3", "hs follows pwm in skip mode");
    pwm = 1'b0;
    tick(10);
    chk(hs, 1'b0, "R3", "hs off, pwm low, skip");
    chk(ls, 1'b0, "R3", "ls stays off, skip");
    sync_m = 1'b1;
    tick(2);
    chk(ls, 1'b1, "R3", "ls restored in sync mode");
    // Disable
    g_req = "R2";
    dis_n = 1'b0;
    tick(3);
    chk(ls, 1'b0, "R2", "ls off when disabled");
    pwm = 1'b1;
    tick(10);
    chk(hs, 1'b0, "R2", "hs off when disabled");
    g_req = "R9";
    dis_n = 1'b1;
    tick(10);
    chk(hs, 1'b0, "R9", "hs off after release with pwm high");
    chk(ls, 1'b0, "R9", "ls off after release with pwm high");
    pwm = 1'b0;
    tick(10);
    chk(ls, 1'b1, "R9", "ls on after pwm low sampled");
    // Cancel a pending high-side turn-on
    g_req = "R7";
    pwm = 1'b1; fb_lsg = 1'b0;
    tick(6);
    base = hs_hits;
    fb_lsg = 1'b1;
    tick(2);
    pwm = 1'b0;
    tick(10);
    chk(hs_hits != base, 1'b0, "R7", "hs pulsed after cancel");
    chk(ls, 1'b1, "R7", "ls sequence restarted");
    // Cancel a pending low-side turn-on
    pwm = 1'b1;
    tick(10);
    pwm = 1'b0; fb_sw = 1'b0; fb_hsg = 1'b0;
    tick(5);
    base = ls_hits;
    fb_sw = 1'b1;
    tick(2);
    pwm = 1'b1;
    tick(10);
    chk(ls_hits != base, 1'b0, "R7", "ls pulsed after cancel");
    chk(hs, 1'b1, "R7", "hs sequence restarted");
    // Lockout enter / exit
    g_req = "R8";
    uv_en = 1'b1; tick(1); uv_en = 1'b0;
    tick(3);
    chk(hs, 1'b0, "R8", "hs off in lockout");
    for (int k = 0; k < 4; k++) begin
      pwm = ~pwm;
      tick(5);
      chk(hs || ls, 1'b0, "R8", "gates off while locked");
    end
    uv_en = 1'b1; uv_ex = 1'b1; tick(1); uv_en = 1'b0; uv_ex = 1'b0;
    pwm = 1'b0;
    tick(12);
    chk(ls, 1'b0, "R8", "enter wins over exit");
    uv_ex = 1'b1; tick(1); uv_ex = 1'b0;
    tick(12);
    chk(ls, 1'b1, "R8", "ls resumes after lockout exit");
    // Random stimulus against the reference
    g_req = "R1";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) pwm = ~pwm;
      if ($urandom_range(79) == 0) dis_n = ~dis_n;
      if ($urandom_range(49) == 0) sync_m = ~sync_m;
      uv_en  = ($urandom_range(299) == 0);
      uv_ex  = ($urandom_range(59) == 0);
      if ($urandom_range(3) == 0) fb_lsg = ~pwm ? 1'b0 : $urandom_range(1);
      if ($urandom_range(3) == 0) fb_sw  = pwm ? 1'b0 : $urandom_range(1);
      if ($urandom_range(5) == 0) fb_hsg = $urandom_range(1);
      tick(1);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule